// File: doc/BRIEF.md
# Complementary Dead-Time Generator

The block turns a single PWM reference into a main output and its complement, and keeps the two apart. Each time the reference changes level, the output that is switching off drops at once. The output that is switching on waits for a programmable gap, and both stay inactive for that time. The clock is the dead-time tick. An 8-bit code sets the gap. The code is decoded in four ranges, each with its own offset and tick multiplier. This gives one-tick resolution for short gaps and coarser steps up to 1008 ticks for long ones.

The code is held in an internal register and loaded by a write strobe. A two-bit lock level protects it: at any nonzero level, writes are dropped. Reset clears the code to zero. A zero code gives no gap, so the outputs then follow the reference and its inverse.

Top module: `dt_pair_gen`

## Requirements
- R1: After reset the code is zero, `out_main` is 0 and `out_comp` is 1.
- R2: A write (`dt_code_wr` high) while `lock_lvl` is 0 loads `dt_code`. The new code sets the gap for reference edges sampled from the next clock edge on.
- R3: A write while `lock_lvl` is 1, 2 or 3 is ignored. Later edges keep the gap of the previously stored code.
- R4: Codes with bit 7 = 0 give a gap of code[6:0] ticks.
- R5: Codes with bits 7:6 = 10 give a gap of (64 + code[5:0]) × 2 ticks.
- R6: Codes with bits 7:5 = 110 give a gap of (32 + code[4:0]) × 8 ticks.
- R7: Codes with bits 7:5 = 111 give a gap of (32 + code[4:0]) × 16 ticks.
- R8: `out_main` and `out_comp` are never high together.
- R9: On a reference edge sampled at clock edge k, with a nonzero gap D, both outputs are low after edge k. The output that matches the new level (`out_main` for 1, `out_comp` for 0) goes high at edge k+D.
- R10: If the reference changes again before the gap ends, the count restarts from the current code. The output that was pending never goes high, and both stay low until the new gap ends.
- R11: With a gap of zero, the outputs take the sampled reference and its inverse at the same clock edge that samples the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one dead-time tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_ref | input | 1 | PWM reference level |
| dt_code | input | 8 | Dead-time code to store |
| dt_code_wr | input | 1 | Write strobe for `dt_code` |
| lock_lvl | input | 2 | Lock level; nonzero blocks writes |
| out_main | output | 1 | Main output, active high |
| out_comp | output | 1 | Complementary output, active high |

## Verification
Every result lands on a known clock edge.
- A code write takes effect for a reference change driven in the next cycle.
- A reference change sampled at edge k clears the switching-off output at edge k.
- The switching-on output rises at edge k+D, where D is the gap the bench computes from the code.

The bench drives every input on the falling edge and samples the outputs on falling edges only. After each reference change it counts the falling edges on which both outputs are low. It then compares that count and the winning output with the computed gap, so every check falls half a cycle after the edge that produces the result.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int CODE_W = 8;
    localparam int LOCK_W = 2;
    // largest decoded gap is (32 + 31) * 16 = 1008 ticks
    localparam int MAX_TICKS = 1008;
    localparam int TICK_W = $clog2(MAX_TICKS + 1);

    typedef logic [CODE_W-1:0] dt_code_t;
endpackage

// File: rtl/dtg_code_reg.sv
module dtg_code_reg
    import dtg_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int LW = LOCK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] wr_code,
    input  logic          wr_en,
    input  logic [LW-1:0] lock,
    output logic [CW-1:0] code
);
    typedef struct packed {
        logic [CW-1:0] code;
    } creg_t;

    creg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (lock == '0)) begin
            st_d.code = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock != '0) |=> $stable(code));

    assert_open_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock == '0) |=> (code == $past(wr_code)));
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
    import dtg_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int TW = TICK_W
) (
    input  logic [CW-1:0] code,
    output logic [TW-1:0] ticks
);
    // Ranges 10x, 110 and 111 add a fixed offset: 64 + x (x < 64) and
    // 32 + x (x < 32) equal a leading one above x. The tick multiplier
    // then becomes a left shift.
    always_comb begin
        casez (code[7:5])
            3'b0??:  ticks = TW'(code[6:0]);
            3'b10?:  ticks = TW'({1'b1, code[5:0], 1'b0});
            3'b110:  ticks = TW'({1'b1, code[4:0], 3'b000});
            default: ticks = TW'({1'b1, code[4:0], 4'b0000});
        endcase
    end
endmodule

// File: rtl/dtg_delay_core.sv
module dtg_delay_core
    import dtg_pkg::*;
#(
    parameter int TW = TICK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic [TW-1:0] gap_ticks,
    output logic          main_o,
    output logic          comp_o
);
    typedef struct packed {
        logic          ref_lvl;
        logic [TW-1:0] cnt;
        logic          main;
        logic          comp;
    } core_t;

    core_t st_d, st_q;
    logic  edge_seen;

    assign edge_seen = (ref_in != st_q.ref_lvl);

    always_comb begin
        st_d = st_q;
        if (edge_seen) begin
            st_d.ref_lvl = ref_in;
            if (gap_ticks == '0) begin
                st_d.cnt  = '0;
                st_d.main = ref_in;
                st_d.comp = !ref_in;
            end else begin
                // restart on every edge; pending output is dropped
                st_d.cnt  = gap_ticks;
                st_d.main = 1'b0;
                st_d.comp = 1'b0;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == TW'(1)) begin
                st_d.main = st_q.ref_lvl;
                st_d.comp = !st_q.ref_lvl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ref_lvl <= 1'b0;
            st_q.cnt     <= '0;
            st_q.main    <= 1'b0;
            st_q.comp    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_o = st_q.main;
    assign comp_o = st_q.comp;

    assert_pair_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_o && comp_o));

    assert_gap_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && gap_ticks != '0) |=> (!main_o && !comp_o));

    assert_direct_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && gap_ticks == '0) |=> (main_o == $past(ref_in) && comp_o == !$past(ref_in)));

    assert_gap_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_seen && st_q.cnt == TW'(1)) |=> (main_o == $past(ref_in) && comp_o == !$past(ref_in)));
endmodule

// File: rtl/dt_pair_gen.sv
module dt_pair_gen
    import dtg_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int LW = LOCK_W,
    parameter int TW = TICK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_ref,
    input  logic [CW-1:0] dt_code,
    input  logic          dt_code_wr,
    input  logic [LW-1:0] lock_lvl,
    output logic          out_main,
    output logic          out_comp
);
    logic [CW-1:0] code_q;
    logic [TW-1:0] gap_ticks;

    dtg_code_reg #(.CW(CW), .LW(LW)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_code (dt_code),
        .wr_en   (dt_code_wr),
        .lock    (lock_lvl),
        .code    (code_q)
    );

    dtg_decode #(.CW(CW), .TW(TW)) u_dec (
        .code  (code_q),
        .ticks (gap_ticks)
    );

    dtg_delay_core #(.TW(TW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (pwm_ref),
        .gap_ticks (gap_ticks),
        .main_o    (out_main),
        .comp_o    (out_comp)
    );
endmodule

// File: tb/sim_dt_pair_gen.sv
`timescale 1ns/1ps
module sim_dt_pair_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_ref = 1'b0;
    logic [7:0] dt_code = '0;
    logic       dt_code_wr = 1'b0;
    logic [1:0] lock_lvl = '0;
    logic       out_main, out_comp;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dt_pair_gen u0 (
        .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .dt_code(dt_code),
        .dt_code_wr(dt_code_wr), .lock_lvl(lock_lvl),
        .out_main(out_main), .out_comp(out_comp)
    );

    function automatic int gap_of(input logic [7:0] c);
        if (!c[7])               return int'(c[6:0]);
        else if (c[7:6] == 2'b10) return (64 + int'(c[5:0])) * 2;
        else if (c[7:5] == 3'b110) return (32 + int'(c[4:0])) * 8;
        else                      return (32 + int'(c[4:0])) * 16;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called right after a falling edge; ends on a falling edge
    task automatic write_code(input logic [7:0] c, input logic [1:0] lk);
        dt_code = c; lock_lvl = lk; dt_code_wr = 1'b1;
        @(negedge clk);
        dt_code_wr = 1'b0; lock_lvl = 2'd0;
    endtask

    task automatic measure_edge(input logic lvl, input int exp, input string req);
        int n = 0;
        bit both = 1'b0;
        pwm_ref = lvl;
        @(posedge clk);
        @(negedge clk);
        while (!out_main && !out_comp && n < 2000) begin
            n++;
            @(negedge clk);
        end
        if (out_main && out_comp) both = 1'b1;
        check(!both, "R8", int'(out_main), 0);
        check(n == exp, req, n, exp);
        check(out_main == lvl && out_comp == !lvl, "R9", int'(out_main), int'(lvl));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_main == 1'b0 && out_comp == 1'b1, "R1", int'({out_main, out_comp}), 1);

        // R1/R11: reset code is zero, so outputs follow directly
        measure_edge(1'b1, 0, "R11");
        measure_edge(1'b0, 0, "R11");

        // directed range corners (R2 load each time)
        write_code(8'h01, 2'd0); measure_edge(1'b1, 1, "R4");
        measure_edge(1'b0, 1, "R4");
        write_code(8'h7F, 2'd0); measure_edge(1'b1, 127, "R4");
        write_code(8'h80, 2'd0); measure_edge(1'b0, 128, "R5");
        write_code(8'hBF, 2'd0); measure_edge(1'b1, 254, "R5");
        write_code(8'hC0, 2'd0); measure_edge(1'b0, 256, "R6");
        write_code(8'hDF, 2'd0); measure_edge(1'b1, 504, "R6");
        write_code(8'hE0, 2'd0); measure_edge(1'b0, 512, "R7");
        write_code(8'hFF, 2'd0); measure_edge(1'b1, 1008, "R7");
        write_code(8'h05, 2'd0); measure_edge(1'b0, 5, "R2");

        // R3: writes at every nonzero lock level are ignored
        for (int lk = 1; lk < 4; lk++) begin
            write_code(8'h30, 2'(lk));
            measure_edge(lk[0] ? 1'b1 : 1'b0, 5, "R3");
        end
        if (pwm_ref) measure_edge(1'b0, 5, "R3");

        // R10: re-edge before the gap ends restarts the count
        write_code(8'h10, 2'd0);
        pwm_ref = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!out_main && !out_comp, "R10", int'({out_main, out_comp}), 0);
        end
        measure_edge(1'b0, 16, "R10");

        // constrained random codes, both edge directions
        for (int i = 0; i < 12; i++) begin
            logic [7:0] c;
            c = 8'($urandom_range(0, 255));
            write_code(c, 2'd0);
            measure_edge(1'b1, gap_of(c), "R4-7 random");
            measure_edge(1'b0, gap_of(c), "R9 random");
        end

        // R11 again after returning to zero code
        write_code(8'h00, 2'd0);
        measure_edge(1'b1, 0, "R11");
        measure_edge(1'b0, 0, "R11");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule